// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from a three-wire serial EEPROM laid out as 128 words of 16 bits. A one-cycle start request, together with a word address, launches a complete transaction. The block releases the protect line, selects the device, and shifts out an 11-bit command frame. The frame is a 3-bit read opcode followed by an 8-bit address. The block then clocks in 16 data bits, deselects the device, re-asserts protect, and reports the word with a one-cycle done pulse.

The serial clock is derived from the system clock. Every phase of the pin sequence lasts exactly `HALF_CYC` system cycles. This covers each clock level, each select and protect step, and each data bit. A whole transaction therefore takes 61 phases. The opcodes for write enable, write, write-all and programming disable are kept as constants for the frame builder. Only the read command is issued.

Top module: `serial_rom_reader`

## Requirements
- R1: After reset, romSel, romClk, romDout and readDone are 0, romLock is 1 and readWord is 0.
- R2: The command frame is 11 bits on romDout, each stable across a rising romClk. It is the read opcode 1,1,0, then wordAddr from bit 7 down to bit 0. Its first bit is the first 1 seen at a rising edge after select.
- R3: After the frame, 16 more rising edges occur with romSel high. romDin is sampled at the end of each high phase and assembled most significant bit first.
- R4: readDone is high for exactly one cycle, 61*HALF_CYC cycles after the edge that accepted the start. readWord carries the new word in that same cycle.
- R5: readWord does not change outside the cycle in which readDone is high.
- R6: A start request that arrives while a transaction is in progress is ignored. The transaction's address, result and timing are unchanged, and no extra done pulse results.
- R7: Before select, romLock, romClk and romDout are low for HALF_CYC cycles. romSel then rises with romClk low. romClk rises HALF_CYC cycles later.
- R8: romDout is low throughout the 16-bit readback.
- R9: Deselect runs in this order, one phase per step: romClk low, then romSel low, then romLock high, then one romClk high phase. After that, romClk returns low at idle.
- R10: While romSel is high, every romClk high level lasts exactly HALF_CYC cycles. A transaction has 28 rising edges in that time: one at select, 11 for the frame and 16 for readback.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle request to read a word |
| wordAddr | input | ADDR_W | Word address, captured with an accepted start |
| romDin | input | 1 | Serial data from the EEPROM |
| romSel | output | 1 | Device chip select, active high |
| romClk | output | 1 | Serial clock to the EEPROM |
| romDout | output | 1 | Serial command data to the EEPROM |
| romLock | output | 1 | Protect enable, high when idle |
| readDone | output | 1 | One-cycle pulse when readWord is updated |
| readWord | output | DATA_W | Last word read, held between transactions |

## Verification
The done pulse and the new word are due 61*HALF_CYC cycles after the accepting edge. The bench counts falling edges from that edge and requires the pulse at exactly that count, and gone one count later. Pin-level order and phase lengths are checked by a bus monitor that samples a quarter cycle after each rising edge. The monitor counts phase widths in whole cycles and plays the EEPROM, driving romDin one phase before the reader's sampling edge. Mid-transfer holds of readWord are sampled a fixed 40 cycles into each transaction, while a stray start is placed at cycle 30.

// File: rtl/srr_pkg.sv
package srr_pkg;

  // Opcodes kept in 16-bit left-aligned form; the top OP_W bits form the frame head.
  typedef enum logic [15:0] {
    OP_PROG_OFF  = 16'h8000,
    OP_WRITE_ALL = 16'h8800,
    OP_WRITE_EN  = 16'h9800,
    OP_WRITE     = 16'hA000,
    OP_READ      = 16'hC000
  } mwOpcode_e;

  localparam int OP_W = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PREP, ST_CS_UP, ST_CK_UP,
    ST_CMD_LO, ST_CMD_HI, ST_RD_LO, ST_RD_HI,
    ST_DS_CKLO, ST_DS_CSLO, ST_DS_LOCK, ST_DS_CKHI
  } srrState_e;

  typedef struct packed {
    logic load;
    logic shiftCmd;
    logic sampleIn;
    logic commit;
  } srrStrobe_t;

  typedef struct packed {
    logic sel;
    logic clk;
    logic lock;
    logic cmdPhase;
  } srrPins_t;

  function automatic srrPins_t pinsFor(srrState_e s);
    srrPins_t p;
    p.sel      = s inside {ST_CS_UP, ST_CK_UP, ST_CMD_LO, ST_CMD_HI,
                           ST_RD_LO, ST_RD_HI, ST_DS_CKLO};
    p.clk      = s inside {ST_CK_UP, ST_CMD_HI, ST_RD_HI, ST_DS_CKHI};
    p.lock     = s inside {ST_IDLE, ST_DS_LOCK, ST_DS_CKHI};
    p.cmdPhase = s inside {ST_CMD_LO, ST_CMD_HI};
    return p;
  endfunction

endpackage

// File: rtl/srr_ctrl.sv
module srr_ctrl
  import srr_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int FRAME_W  = 11,
  parameter int DATA_W   = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  output srrStrobe_t stb,
  output srrPins_t   pins,
  output logic       readDone
);

  localparam int PH_W    = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int CNT_MAX = (FRAME_W > DATA_W) ? FRAME_W : DATA_W;
  localparam int BIT_W   = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;
  localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] FRAME_LAST = BIT_W'(FRAME_W - 1);
  localparam logic [BIT_W-1:0] DATA_LAST  = BIT_W'(DATA_W - 1);

  srrState_e        state, stateD;
  logic [PH_W-1:0]  phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             phaseEnd, lastBit;

  assign phaseEnd = (phaseCnt == PH_LAST);
  assign lastBit  = (state == ST_CMD_HI) ? (bitCnt == FRAME_LAST) : (bitCnt == DATA_LAST);

  always_comb begin
    stateD = state;
    case (state)
      ST_IDLE:    if (startReq) stateD = ST_PREP;
      ST_PREP:    if (phaseEnd) stateD = ST_CS_UP;
      ST_CS_UP:   if (phaseEnd) stateD = ST_CK_UP;
      ST_CK_UP:   if (phaseEnd) stateD = ST_CMD_LO;
      ST_CMD_LO:  if (phaseEnd) stateD = ST_CMD_HI;
      ST_CMD_HI:  if (phaseEnd) stateD = lastBit ? ST_RD_LO : ST_CMD_LO;
      ST_RD_LO:   if (phaseEnd) stateD = ST_RD_HI;
      ST_RD_HI:   if (phaseEnd) stateD = lastBit ? ST_DS_CKLO : ST_RD_LO;
      ST_DS_CKLO: if (phaseEnd) stateD = ST_DS_CSLO;
      ST_DS_CSLO: if (phaseEnd) stateD = ST_DS_LOCK;
      ST_DS_LOCK: if (phaseEnd) stateD = ST_DS_CKHI;
      ST_DS_CKHI: if (phaseEnd) stateD = ST_IDLE;
      default:    stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    stb.load     = (state == ST_IDLE) && startReq;
    stb.shiftCmd = (state == ST_CMD_HI) && phaseEnd;
    stb.sampleIn = (state == ST_RD_HI) && phaseEnd;
    stb.commit   = (state == ST_DS_CKHI) && phaseEnd;
  end

  // Pins are registered from the next state, so they line up with the state register.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pins     <= pinsFor(ST_IDLE);
      phaseCnt <= '0;
      bitCnt   <= '0;
      readDone <= 1'b0;
    end else begin
      state    <= stateD;
      pins     <= pinsFor(stateD);
      readDone <= stb.commit;
      phaseCnt <= (state == ST_IDLE || phaseEnd) ? '0 : phaseCnt + 1'b1;
      if ((state == ST_CMD_HI || state == ST_RD_HI) && phaseEnd)
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  // R10: a busy phase holds its state until its last cycle
  a_r10_phase_len: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !phaseEnd) |=> (state == $past(state)));

  // R6: a transaction only begins from idle
  a_r6_prep_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PREP && $past(state) != ST_PREP) |-> ($past(state) == ST_IDLE));

  // R4: the done pulse lands in idle with the device released
  a_r4_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    readDone |-> (state == ST_IDLE && pins.lock && !pins.sel));

endmodule

// File: rtl/srr_datapath.sv
module srr_datapath
  import srr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  srrStrobe_t        stb,
  input  logic              cmdPhase,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              romDin,
  output logic              romDout,
  output logic [DATA_W-1:0] readWord
);

  localparam int FRAME_W = OP_W + ADDR_W;
  localparam logic [15:0]     READ_FORM = OP_READ;
  localparam logic [OP_W-1:0] READ_HEAD = READ_FORM[15 -: OP_W];

  logic [FRAME_W-1:0] cmdShift;
  logic [DATA_W-1:0]  rxShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdShift <= '0;
      rxShift  <= '0;
      readWord <= '0;
    end else begin
      if (stb.load)
        cmdShift <= {READ_HEAD, wordAddr};
      else if (stb.shiftCmd)
        cmdShift <= {cmdShift[FRAME_W-2:0], 1'b0};
      if (stb.sampleIn)
        rxShift <= {rxShift[DATA_W-2:0], romDin};
      if (stb.commit)
        readWord <= rxShift;
    end
  end

  // Outside the frame phases the data line is forced low.
  assign romDout = cmdPhase & cmdShift[FRAME_W-1];

endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
  import srr_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] wordAddr,
  input  logic              romDin,
  output logic              romSel,
  output logic              romClk,
  output logic              romDout,
  output logic              romLock,
  output logic              readDone,
  output logic [DATA_W-1:0] readWord
);

  localparam int FRAME_W = OP_W + ADDR_W;

  srrStrobe_t stb;
  srrPins_t   pins;

  srr_ctrl #(.HALF_CYC(HALF_CYC), .FRAME_W(FRAME_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .stb(stb), .pins(pins), .readDone(readDone)
  );

  srr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdPhase(pins.cmdPhase),
    .wordAddr(wordAddr), .romDin(romDin), .romDout(romDout), .readWord(readWord)
  );

  assign romSel  = pins.sel;
  assign romClk  = pins.clk;
  assign romLock = pins.lock;

  // R4: done is a single-cycle pulse
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    readDone |=> !readDone);

  // R5: the result only moves together with done
  a_r5_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    !readDone |-> $stable(readWord));

  // R7: select rises with protect released and clock low
  a_r7_sel_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romSel) |-> (!romLock && !romClk));

  // R9: protect returns only after select has dropped
  a_r9_lock_after_desel: assert property (@(posedge clk) disable iff (!rstN)
    $rose(romLock) |-> (!romSel && !romClk));

endmodule

// File: tb/tb_serial_rom_reader.sv
module tb_serial_rom_reader;

  localparam int HALF   = 3;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int TOTAL  = 61 * HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [ADDR_W-1:0] wordAddr = '0;
  logic romDin = 1'b0;
  logic romSel, romClk, romDout, romLock, readDone;
  logic [DATA_W-1:0] readWord;

  int checks = 0;
  int failures = 0;

  serial_rom_reader #(.HALF_CYC(HALF), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wordAddr(wordAddr), .romDin(romDin),
    .romSel(romSel), .romClk(romClk), .romDout(romDout), .romLock(romLock),
    .readDone(readDone), .readWord(readWord)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] romWord(logic [7:0] a);
    return {a, ~a} ^ 16'h3C5A;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bus monitor and EEPROM model, sampling 5 ns after each rising system edge.
  logic prevSel = 0, prevClk = 0, prevLock = 1;
  bit started = 0, dsStage = 0, dsClkSeen = 0;
  int bitCnt = 0, rdCnt = 0, riseCnt = 0, highLen = 0, lockLowLen = 0, selAge = 0, doneCnt = 0;
  logic [10:0] frameBits = '0;
  int seqErr = 0, doutErr = 0, dsErr = 0, widthErr = 0, ageErr = 0;

  always @(posedge clk) begin
    #5;
    if (readDone) doneCnt++;
    if (romSel && bitCnt == 11 && (rdCnt > 0 || !romClk) && romDout) doutErr++;
    if (!romLock && !romSel) lockLowLen++;
    else if (romLock) lockLowLen = 0;
    if (romSel && !prevSel) begin
      selAge = 0;
      if (romLock || romClk || romDout || lockLowLen != HALF) seqErr++;
    end else if (romSel) selAge++;
    if (romClk && romSel) highLen++;
    if (prevClk && !romClk && romSel) begin
      if (highLen != HALF) widthErr++;
      highLen = 0;
    end
    if (romClk && !prevClk && romSel) begin
      if (riseCnt == 0 && selAge != HALF) ageErr++;
      riseCnt++;
      if (!started) begin
        if (romDout) begin started = 1; frameBits = {10'b0, 1'b1}; bitCnt = 1; end
      end else if (bitCnt < 11) begin
        frameBits = {frameBits[9:0], romDout};
        bitCnt++;
      end else if (rdCnt < 16) begin
        romDin = (frameBits[10:8] == 3'b110) ? romWord(frameBits[7:0])[15 - rdCnt] : 1'b0;
        rdCnt++;
      end
    end
    if (prevSel && !romSel) begin
      if (romClk || romLock) dsErr++;
      started = 0; bitCnt = 0; rdCnt = 0;
    end
    if (!prevLock && romLock) begin
      if (romSel || romClk) dsErr++;
      dsStage = 1;
    end
    if (romClk && !prevClk && !romSel && romLock && dsStage) dsClkSeen = 1;
    prevSel = romSel; prevClk = romClk; prevLock = romLock;
  end

  task automatic clearMon();
    seqErr = 0; doutErr = 0; dsErr = 0; widthErr = 0; ageErr = 0;
    riseCnt = 0; doneCnt = 0; dsStage = 0; dsClkSeen = 0; frameBits = '0;
  endtask

  task automatic testReset();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(romSel == 0, "R1", "romSel after reset", romSel, 0);
    check(romClk == 0, "R1", "romClk after reset", romClk, 0);
    check(romDout == 0, "R1", "romDout after reset", romDout, 0);
    check(romLock == 1, "R1", "romLock after reset", romLock, 1);
    check(readDone == 0, "R1", "readDone after reset", readDone, 0);
    check(readWord == 0, "R1", "readWord after reset", readWord, 0);
  endtask

  task automatic readOne(logic [7:0] addr, bit intrude);
    logic [15:0] prevWord = readWord;
    logic [15:0] midWord = '0;
    int cnt = 0;
    clearMon();
    @(negedge clk);
    wordAddr = addr;
    startReq = 1;
    @(negedge clk);
    startReq = 0;
    while (!readDone && cnt < 4000) begin
      if (intrude) begin
        startReq = (cnt == 30);
        wordAddr = (cnt == 30) ? (addr ^ 8'hFF) : addr;
      end
      if (cnt == 40) midWord = readWord;
      @(negedge clk);
      cnt++;
    end
    startReq = 0;
    check(cnt == TOTAL, "R4", "cycles to done", cnt, TOTAL);
    check(readWord == romWord(addr), "R3", "word read", readWord, romWord(addr));
    check(frameBits == {3'b110, addr}, "R2", "command frame", frameBits, {3'b110, addr});
    check(midWord == prevWord, "R5", "word held mid-transfer", midWord, prevWord);
    check(riseCnt == 28, "R10", "rising edges while selected", riseCnt, 28);
    check(widthErr == 0, "R10", "clock high width errors", widthErr, 0);
    check(seqErr == 0 && ageErr == 0, "R7", "select sequence errors", seqErr + ageErr, 0);
    check(doutErr == 0, "R8", "data out high in readback", doutErr, 0);
    check(dsErr == 0 && dsClkSeen, "R9", "deselect order", dsErr, 0);
    @(negedge clk);
    check(readDone == 0, "R4", "done lasts one cycle", readDone, 0);
    check(doneCnt == 1, "R6", "done pulses per transaction", doneCnt, 1);
    check(romClk == 0 && romSel == 0 && romLock == 1, "R9", "idle pins after deselect",
          {romClk, romSel, romLock}, 3'b001);
    repeat (5) @(negedge clk);
    check(readWord == romWord(addr), "R5", "word held after done", readWord, romWord(addr));
    check(readDone == 0 && romSel == 0, "R6", "no second transaction", {readDone, romSel}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    readOne(8'h00, 0);
    readOne(8'h5A, 0);
    readOne(8'hFF, 0);
    readOne(8'h7F, 1);   // R6: stray start mid-transfer
    readOne(8'hA3, 1);
    readOne(8'h01, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule